// File: doc/BRIEF.md
# Address-Filtering Asynchronous Serial Receiver

This block receives asynchronous serial frames on a single line, using an external tick that runs at sixteen times the bit rate. Each frame carries 7, 8 or 9 data bits, least significant first. An even or odd parity bit may follow, then one or two stop bits. When a frame is complete it is copied into a receive buffer. At that copy the block updates a small set of status flags: data ready, overrun, framing error and parity error. A summary error flag and a one-cycle interrupt request are derived from them.

Several of these receivers can share one line with a single sender. In sleep mode, a frame whose most significant data bit is 0 is dropped without any trace. A frame with that bit set is taken in the normal way. The sender marks address frames with that bit. Each receiver compares the address and leaves sleep mode only if the address is its own. An active-low ready-to-receive output tells the far end when the receiver is idle and enabled.

Top module: `uart_sleep_rx`

## Requirements
- R1: While `rx_en` is 0 no frame is received, and one cycle after `rx_en` is sampled at 0 the flags `ready`, `overrun`, `frame_err`, `parity_err` and `err_sum` are all 0.
- R2: A frame starts on a high-to-low transition of `rxd` seen at a tick. The start bit is sampled 8 ticks later, and if it is high there the receiver returns to idle with no flag or buffer change.
- R3: `cfg_len` selects the data length (0: 7 bits, 1: 8 bits, 2: 9 bits, 3: 8 bits). Bits arrive least significant first, each sampled 16 ticks after the previous one. The received data appears on `rx_data`, with the unused upper bits set to 0.
- R4: With `cfg_par_en`=1 a parity bit follows the data. `parity_err` is set when the count of ones over data and parity bit is odd (`cfg_par_odd`=0) or even (`cfg_par_odd`=1).
- R5: `frame_err` is set when any of the configured stop bits (one, or two if `cfg_two_stop`=1) is sampled low.
- R6: Flags and buffer change only when a frame is copied to the buffer. The copy sets `ready`. A one-cycle `rd_strobe` clears `ready`, `frame_err` and `parity_err`, but not `overrun`.
- R7: `overrun` is set when a frame is copied while `ready` is 1, and it stays set until `rx_en` goes to 0.
- R8: `err_sum` is 1 exactly when at least one of `overrun`, `frame_err` and `parity_err` is 1.
- R9: `rx_irq` pulses for one cycle when `ready` goes from 0 to 1, and at no other time.
- R10: With `cfg_sleep`=1, a frame whose most significant data bit is 0 leaves the buffer, every flag and `rx_irq` unchanged.
- R11: With `cfg_sleep`=1, a frame whose most significant data bit is 1 is received exactly as it would be with sleep off.
- R12: With `cfg_rts_en`=1, `rts_n` is high while `rx_en` is 0, low while enabled and idle, high from start detection until the frame is copied or rejected, then low again. With `cfg_rts_en`=0 it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample tick, 16 per bit |
| rxd | input | 1 | Serial line |
| rx_en | input | 1 | Receive enable |
| cfg_len | input | 2 | Data length select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_two_stop | input | 1 | Two stop bits checked when 1 |
| cfg_sleep | input | 1 | Sleep (address filter) mode |
| cfg_rts_en | input | 1 | Drive ready-to-receive output |
| rd_strobe | input | 1 | Buffer read, one cycle |
| rx_data | output | 9 | Receive buffer |
| ready | output | 1 | Buffer holds unread data |
| overrun | output | 1 | Frame copied over unread data |
| frame_err | output | 1 | Stop bit low |
| parity_err | output | 1 | Parity mismatch |
| err_sum | output | 1 | Any error flag set |
| rx_irq | output | 1 | Receive interrupt pulse |
| rts_n | output | 1 | Active-low ready to receive |

## Verification
Random frames mix all three lengths, both parity senses, one or two stop bits, sleep on and off, and random reads between frames. Deliberately wrong parity bits and low stop bits separate the parity check from the framing check. Frames that arrive without a read in between separate overrun from a plain ready. In sleep mode, frames with a clear top bit are sent against a buffer whose contents are already known, so a dropped frame can be told apart from one that is received. Directed cases cover a short start glitch, the ready-to-receive output across a frame, and clearing everything by disabling reception.

// File: rtl/uart_sleep_rx.sv
module uart_sleep_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic       cfg_two_stop,
  input  logic       cfg_sleep,
  input  logic       cfg_rts_en,
  input  logic       rd_strobe,
  output logic [8:0] rx_data,
  output logic       ready,
  output logic       overrun,
  output logic       frame_err,
  output logic       parity_err,
  output logic       err_sum,
  output logic       rx_irq,
  output logic       rts_n
);
  typedef enum logic [2:0] {IDLE, START, DATA, PAR, STOP1, STOP2} st_t;
  st_t st;
  logic       rx_q, prev, stop1_bad, par_bad;
  logic [3:0] cnt, bitn, nbits;
  logic [8:0] sh;
  logic       msb, mid, xfer, keep, fe_now;

  always_comb begin
    case (cfg_len)
      2'd0:    nbits = 4'd7;
      2'd2:    nbits = 4'd9;
      default: nbits = 4'd8;
    endcase
  end

  assign msb    = sh[nbits-4'd1];
  assign mid    = os_tick && (cnt == 4'd15);
  assign xfer   = mid && ((st == STOP1 && !cfg_two_stop) || st == STOP2);
  assign keep   = !cfg_sleep || msb;
  assign fe_now = (st == STOP2) ? (stop1_bad || !rx_q) : !rx_q;
  assign err_sum = overrun || frame_err || parity_err;
  assign rts_n  = !(cfg_rts_en && rx_en && st == IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q <= 1'b1; prev <= 1'b1; st <= IDLE; cnt <= '0; bitn <= '0; sh <= '0;
      stop1_bad <= 1'b0; par_bad <= 1'b0; rx_data <= '0;
      ready <= 1'b0; overrun <= 1'b0; frame_err <= 1'b0; parity_err <= 1'b0; rx_irq <= 1'b0;
    end else begin
      rx_q   <= rxd;
      rx_irq <= 1'b0;
      if (!rx_en) begin
        st <= IDLE; prev <= 1'b1;
        ready <= 1'b0; overrun <= 1'b0; frame_err <= 1'b0; parity_err <= 1'b0;
      end else begin
        if (rd_strobe) begin
          ready <= 1'b0; frame_err <= 1'b0; parity_err <= 1'b0;
        end
        if (os_tick) begin
          case (st)
            IDLE: begin
              prev <= rx_q;
              if (prev && !rx_q) begin st <= START; cnt <= '0; end
            end
            START: begin
              if (cnt == 4'd7) begin
                cnt <= '0;
                if (rx_q) begin st <= IDLE; prev <= 1'b1; end
                else begin st <= DATA; bitn <= '0; sh <= '0; par_bad <= 1'b0; end
              end else cnt <= cnt + 4'd1;
            end
            default: begin
              cnt <= cnt + 4'd1;
              if (cnt == 4'd15) begin
                case (st)
                  DATA: begin
                    sh[bitn] <= rx_q;
                    bitn <= bitn + 4'd1;
                    if (bitn == nbits - 4'd1) st <= cfg_par_en ? PAR : STOP1;
                  end
                  PAR: begin
                    par_bad <= (^sh ^ rx_q) != cfg_par_odd;
                    st <= STOP1;
                  end
                  STOP1: begin
                    stop1_bad <= !rx_q;
                    if (cfg_two_stop) st <= STOP2;
                  end
                  default: ;
                endcase
              end
            end
          endcase
        end
        if (xfer) begin
          st   <= IDLE;
          prev <= rx_q;
          if (keep) begin
            rx_data    <= sh;
            ready      <= 1'b1;
            overrun    <= overrun || ready;
            frame_err  <= fe_now;
            parity_err <= par_bad;
            rx_irq     <= !ready;
          end
        end
      end
    end
  end
endmodule

// File: rtl/uart_sleep_rx_chk.sv
module uart_sleep_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic rd_strobe,
  input logic cfg_rts_en,
  input logic ready,
  input logic overrun,
  input logic frame_err,
  input logic parity_err,
  input logic err_sum,
  input logic rx_irq,
  input logic rts_n
);
  a_r1_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!ready && !overrun && !frame_err && !parity_err && !err_sum));
  a_r6_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && rx_en && !rd_strobe) |=> ready);
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && rx_en) |=> overrun);
  a_r9_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (ready && !$past(ready)));
  a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |=> !rx_irq);
  a_r12_rts_after_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rts_en && rx_en && $rose(ready)) |-> !rts_n);
endmodule

bind uart_sleep_rx uart_sleep_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_strobe(rd_strobe), .cfg_rts_en(cfg_rts_en),
  .ready(ready), .overrun(overrun), .frame_err(frame_err), .parity_err(parity_err),
  .err_sum(err_sum), .rx_irq(rx_irq), .rts_n(rts_n));

// File: tb/uart_sleep_rx_test.sv
module uart_sleep_rx_test;
  localparam int BIT = 32;
  logic clk = 0, rst_n = 0, os_tick = 0, rxd = 1, rx_en = 0;
  logic [1:0] cfg_len = 1;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_two_stop = 0, cfg_sleep = 0, cfg_rts_en = 1, rd_strobe = 0;
  logic [8:0] rx_data;
  logic ready, overrun, frame_err, parity_err, err_sum, rx_irq, rts_n;
  int checks = 0, fails = 0, irq_cnt = 0, cyc = 0;
  logic [8:0] e_data = 0;
  logic e_rdy = 0, e_ovr = 0, e_fe = 0, e_pe = 0;
  int e_irq = 0;

  uart_sleep_rx uut (.*);

  always #10 clk = ~clk;
  always @(posedge clk) begin
    os_tick <= ~os_tick;
    cyc <= cyc + 1;
    if (rst_n && rx_irq) irq_cnt <= irq_cnt + 1;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nb(logic [1:0] l);
    return (l == 0) ? 7 : (l == 2) ? 9 : 8;
  endfunction

  task automatic bitout(logic b);
    @(negedge clk) rxd = b;
    repeat (BIT - 1) @(negedge clk);
  endtask

  task automatic send(logic [8:0] d, bit bad_par, bit bad_s1, bit bad_s2);
    int n = nb(cfg_len);
    logic p = cfg_par_odd;
    bitout(0);
    for (int i = 0; i < n; i++) begin bitout(d[i]); p ^= d[i]; end
    if (cfg_par_en) bitout(p ^ bad_par);
    bitout(!bad_s1);
    if (cfg_two_stop) bitout(!bad_s2);
    bitout(1); bitout(1);
  endtask

  task automatic model(logic [8:0] d, bit bad_par, bit bad_s1, bit bad_s2);
    int n = nb(cfg_len);
    logic [8:0] m = d & ((9'h1 << n) - 1);
    if (cfg_sleep && !m[n-1]) return;
    e_ovr = e_ovr | e_rdy;
    if (!e_rdy) e_irq++;
    e_rdy = 1; e_data = m;
    e_fe = bad_s1 || (cfg_two_stop && bad_s2);
    e_pe = cfg_par_en && bad_par;
  endtask

  task automatic rd();
    @(negedge clk) rd_strobe = 1;
    @(negedge clk) rd_strobe = 0;
    e_rdy = 0; e_fe = 0; e_pe = 0;
  endtask

  task automatic check_all(string tag);
    @(negedge clk);
    chk({tag, " R3 data"}, rx_data, e_data);
    chk({tag, " R6 ready"}, ready, e_rdy);
    chk({tag, " R7 overrun"}, overrun, e_ovr);
    chk({tag, " R5 frame_err"}, frame_err, e_fe);
    chk({tag, " R4 parity_err"}, parity_err, e_pe);
    chk({tag, " R8 err_sum"}, err_sum, e_ovr | e_fe | e_pe);
    chk({tag, " R9 irq count"}, irq_cnt, e_irq);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", ready, 0);
    chk("R12 rts while disabled", rts_n, 1);
    rx_en = 1;
    repeat (4) @(negedge clk);
    chk("R12 rts idle enabled", rts_n, 0);

    // R2 glitch: low for 4 ticks only
    @(negedge clk) rxd = 0;
    repeat (8) @(negedge clk);
    rxd = 1;
    repeat (3 * BIT) @(negedge clk);
    chk("R2 glitch rts back low", rts_n, 0);
    check_all("R2 glitch");

    // R12 rts during frame
    fork
      send(9'h0A5, 0, 0, 0);
      begin repeat (3 * BIT) @(negedge clk); chk("R12 rts busy", rts_n, 1); end
    join
    model(9'h0A5, 0, 0, 0);
    check_all("R3 directed");
    chk("R12 rts after copy", rts_n, 0);

    // R7 overrun: second frame unread
    send(9'h13C, 0, 0, 0); model(9'h13C, 0, 0, 0);
    check_all("R7 directed");
    rd(); check_all("R6 read keeps overrun");

    // R10 / R11 sleep directed
    cfg_sleep = 1;
    send(9'h05A, 0, 1, 0); model(9'h05A, 0, 1, 0);
    check_all("R10 dropped frame");
    send(9'h0C1, 0, 0, 0); model(9'h0C1, 0, 0, 0);
    check_all("R11 address frame");
    cfg_sleep = 0;

    // R1 disable clears
    @(negedge clk) rx_en = 0;
    repeat (2) @(negedge clk);
    e_rdy = 0; e_ovr = 0; e_fe = 0; e_pe = 0;
    check_all("R1 disable");
    chk("R12 rts disabled", rts_n, 1);
    send(9'h033, 0, 0, 0);
    check_all("R1 no receive while off");
    rx_en = 1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < 40; k++) begin
      logic [8:0] d = 9'($urandom);
      bit bp = ($urandom % 5) == 0, b1 = ($urandom % 6) == 0, b2 = ($urandom % 6) == 0;
      cfg_len = 2'($urandom % 3);
      cfg_par_en = 1'($urandom); cfg_par_odd = 1'($urandom);
      cfg_two_stop = 1'($urandom); cfg_sleep = ($urandom % 4) == 0;
      if ($urandom % 2) rd();
      send(d, bp, b1, b2); model(d, bp, b1, b2);
      check_all("random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule